// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block turns one 16-bit instruction word of a 32-bit processor with sixteen general registers into decoded control fields. The top two bits of the word pick one of three encodings. The first is a register-register group with a 7-bit primary code. The second is an immediate group with a 2-bit sub-operation, one register and an 8-bit unsigned constant. The third is a compare-and-branch group with a 4-bit condition and a 10-bit displacement. For each word the block reports a unified operation code, the register indices, the immediate, the displacement, the instruction length in bytes and an illegal flag. The length is 6 when a 32-bit extension word follows the opcode word, and 2 otherwise.

A fetch stage presents a word with `in_valid` high. The decoded result appears one clock later with `out_valid` high. A two-state output stage controls this. `ST_IDLE` means no result is held. `ST_SHOW` means the registered result belongs to the word accepted on the previous edge. The transitions are as follows:
- **accept**: `ST_IDLE` goes to `ST_SHOW` when `in_valid` is high.
- **refill**: `ST_SHOW` stays in `ST_SHOW` when `in_valid` is high.
- **drain**: `ST_SHOW` goes to `ST_IDLE` when `in_valid` is low.

The decoded fields hold their last value while no word is offered. The block does not fetch the extension word and does not execute the operation. It also provides hints for the execute stage: whether register A is a source, whether the operation is a shift (the shift amount is the low five bits of register B), and whether it is a trap.

Top module: `opword_decoder`

## Requirements
- R1: Format select. If `in_word[15]`=0, `out_fmt`=1. If `in_word[15:14]`=2'b10, `out_fmt`=2. If `in_word[15:14]`=2'b11, `out_fmt`=3.
- R2: Format 1 fields:
  - `out_op` = `in_word[14:8]` when the code is legal.
  - `out_ra` = `in_word[7:4]` and `out_rb` = `in_word[3:0]`.
  - `out_imm8` = 0 and `out_disp` = 0.
- R3: Format 2 fields:
  - `out_op` = 0x40 + `in_word[13:12]`. The sub-operations are 0 increment, 1 decrement, 2 read special register and 3 write special register.
  - `out_ra` = `in_word[11:8]` and `out_imm8` = `in_word[7:0]`.
  - `out_rb` = 0 and `out_disp` = 0.
  - A format 2 word is never illegal.
- R4: Format 3 fields:
  - `out_disp` = `in_word[9:0]`, and `out_ra`, `out_rb` and `out_imm8` are 0.
  - Conditions 0 to 9 of `in_word[13:10]` give `out_op` = 0x48 + condition.
  - Conditions 10 to 15 are illegal.
- R5: `out_len` is 6 for the format 1 codes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39. It is 2 for every other word.
- R6: Legal format 1 codes are 0x00–0x0E and 0x19–0x39. Any other format 1 code, and any illegal format 3 condition, has this effect:
  - `out_illegal`=1 and `out_op`=0x7F.
  - `out_len`=2.
  - `out_reads_a`, `out_shift` and `out_trap` are all 0.
  - The register, immediate and displacement fields are still extracted as for the word's format.
- R7: `out_reads_a`=1 only for the format 1 codes where A is also a source: 0x05, 0x26, 0x27, 0x28, 0x29, 0x2B, 0x2D, 0x2E and 0x2F. It is 0 for negate (0x2A), bitwise-not (0x2C) and every other word.
- R8: `out_shift`=1 only for format 1 codes 0x27, 0x28 and 0x2D.
- R9: `out_trap`=2'b01 for the software interrupt 0x30, whose extension word goes to special register 3. It is 2'b10 for the breakpoint 0x35 and 2'b00 otherwise.
- R10: A word offered with `in_valid` high is decoded on the output one rising edge later, with `out_valid`=1. `out_valid` is 0 in the cycle after `in_valid` is low.
- R11: While `in_valid` is low, every decoded field keeps its last value.
- R12: After reset the block is in this state:
  - `out_valid`=0 and `out_fmt`=0.
  - `out_op`, the register fields, `out_imm8`, `out_disp`, `out_illegal`, the hints and `out_trap` are 0.
  - `out_len`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_word` holds a word to decode |
| in_word | input | 16 | Instruction opcode word |
| out_valid | output | 1 | Decoded result is for a word accepted on the last edge |
| out_fmt | output | 2 | Encoding group 1, 2 or 3 (0 after reset) |
| out_op | output | 7 | Unified operation code, 0x7F when illegal |
| out_ra | output | 4 | Register A index |
| out_rb | output | 4 | Register B index |
| out_imm8 | output | 8 | Unsigned immediate of format 2 |
| out_disp | output | 10 | Raw branch displacement of format 3 |
| out_len | output | 3 | Instruction length in bytes, 2 or 6 |
| out_illegal | output | 1 | Unassigned encoding |
| out_reads_a | output | 1 | Register A is also a source operand |
| out_shift | output | 1 | Shift operation, amount from low 5 bits of B |
| out_trap | output | 2 | 01 software interrupt, 10 breakpoint |

## Verification
The only state in the block is the output stage and the held result. A wrong stage shows at once as an `out_valid` that disagrees with the `in_valid` of the previous cycle. A stale or missed capture shows as fields that change during a bubble, or that fail to change one edge after a valid word. Table errors in the primary-code decode show as a wrong length, legality or hint for that one code on the very next cycle. For this reason, every format 1 code, every format 2 sub-operation and every format 3 condition is offered at least once, with bubbles mixed in.

// File: rtl/opdec_pkg.sv
`timescale 1ns/1ps
package opdec_pkg;
    localparam int WORD_W = 16;
    localparam int PRIM_W = 8;
    localparam int RIDX_W = 4;
    localparam int IMM_W  = 8;
    localparam int DISP_W = 10;
    localparam int OP_W   = 7;
    localparam int LEN_W  = 3;
    localparam int COND_W = 4;
    localparam int BRANCH_CONDS = 10;

    localparam logic [OP_W-1:0]  OPC_MINOR_BASE  = 7'h40;
    localparam logic [OP_W-1:0]  OPC_BRANCH_BASE = 7'h48;
    localparam logic [OP_W-1:0]  OPC_BAD         = 7'h7F;
    localparam logic [LEN_W-1:0] LEN_SHORT       = 3'd2;
    localparam logic [LEN_W-1:0] LEN_LONG        = 3'd6;

    typedef enum logic [1:0] {
        FMT_NONE  = 2'd0,
        FMT_ONE   = 2'd1,
        FMT_TWO   = 2'd2,
        FMT_THREE = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_SOFT  = 2'd1,
        TRAP_BREAK = 2'd2
    } trap_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } stage_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
        logic [DISP_W-1:0] disp;
        logic [LEN_W-1:0]  len;
        logic              bad;
        logic              reads_a;
        logic              shift;
        trap_e             trap;
    } dec_t;
endpackage

// File: rtl/opdec_primary.sv
`timescale 1ns/1ps
module opdec_primary
    import opdec_pkg::*;
(
    input  logic [PRIM_W-1:0] prim,
    output logic              legal,
    output logic              ext_word,
    output logic              reads_a,
    output logic              shift,
    output trap_e             trap
);
    always_comb begin
        legal    = (prim <= 8'h0E) || ((prim >= 8'h19) && (prim <= 8'h39));
        ext_word = prim inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
                                8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
                                8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
        reads_a  = prim inside {8'h05, 8'h26, 8'h27, 8'h28, 8'h29,
                                8'h2B, 8'h2D, 8'h2E, 8'h2F};
        shift    = prim inside {8'h27, 8'h28, 8'h2D};
        if (prim == 8'h30)      trap = TRAP_SOFT;
        else if (prim == 8'h35) trap = TRAP_BREAK;
        else                    trap = TRAP_NONE;
    end
endmodule

// File: rtl/opdec_minor.sv
`timescale 1ns/1ps
module opdec_minor
    import opdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OP_W-1:0]   imm_op,
    output logic [OP_W-1:0]   br_op,
    output logic              br_legal
);
    logic [COND_W-1:0] cond;

    always_comb begin
        cond     = word[13:10];
        imm_op   = OPC_MINOR_BASE + OP_W'(word[13:12]);
        br_legal = (int'(cond) < BRANCH_CONDS);
        br_op    = OPC_BRANCH_BASE + OP_W'(cond);
    end
endmodule

// File: rtl/opword_decoder.sv
`timescale 1ns/1ps
module opword_decoder
    import opdec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_word,
    output logic                    out_valid,
    output logic [1:0]              out_fmt,
    output logic [OP_W-1:0]         out_op,
    output logic [RIDX_W-1:0]       out_ra,
    output logic [RIDX_W-1:0]       out_rb,
    output logic [IMM_W-1:0]        out_imm8,
    output logic [DISP_W-1:0]       out_disp,
    output logic [LEN_W-1:0]        out_len,
    output logic                    out_illegal,
    output logic                    out_reads_a,
    output logic                    out_shift,
    output logic [1:0]              out_trap
);
    logic       p_legal, p_ext, p_reads_a, p_shift;
    trap_e      p_trap;
    logic [OP_W-1:0] m_imm_op, m_br_op;
    logic       m_br_legal;
    dec_t       nx, dec_q;
    stage_e     stage_q, stage_d;

    opdec_primary u_primary (
        .prim     ({1'b0, in_word[14:8]}),
        .legal    (p_legal),
        .ext_word (p_ext),
        .reads_a  (p_reads_a),
        .shift    (p_shift),
        .trap     (p_trap)
    );

    opdec_minor u_minor (
        .word     (in_word),
        .imm_op   (m_imm_op),
        .br_op    (m_br_op),
        .br_legal (m_br_legal)
    );

    always_comb begin
        nx      = '0;
        nx.fmt  = FMT_NONE;
        nx.trap = TRAP_NONE;
        nx.len  = LEN_SHORT;
        unique case (in_word[15:14])
            2'b00, 2'b01: begin
                nx.fmt     = FMT_ONE;
                nx.op      = in_word[14:8];
                nx.ra      = in_word[7:4];
                nx.rb      = in_word[3:0];
                nx.bad     = !p_legal;
                nx.len     = p_ext ? LEN_LONG : LEN_SHORT;
                nx.reads_a = p_reads_a;
                nx.shift   = p_shift;
                nx.trap    = p_trap;
            end
            2'b10: begin
                nx.fmt = FMT_TWO;
                nx.op  = m_imm_op;
                nx.ra  = in_word[11:8];
                nx.imm = in_word[7:0];
            end
            2'b11: begin
                nx.fmt  = FMT_THREE;
                nx.op   = m_br_op;
                nx.disp = in_word[9:0];
                nx.bad  = !m_br_legal;
            end
        endcase
        if (nx.bad) begin
            nx.op      = OPC_BAD;
            nx.len     = LEN_SHORT;
            nx.reads_a = 1'b0;
            nx.shift   = 1'b0;
            nx.trap    = TRAP_NONE;
        end
    end

    always_comb begin
        unique case (stage_q)
            ST_IDLE: stage_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: stage_d = in_valid ? ST_SHOW : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= ST_IDLE;
        else        stage_q <= stage_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q      <= '0;
            dec_q.fmt  <= FMT_NONE;
            dec_q.trap <= TRAP_NONE;
            dec_q.len  <= LEN_SHORT;
        end else if (in_valid) begin
            dec_q <= nx;
        end
    end

    always_comb begin
        unique case (stage_q)
            ST_IDLE: out_valid = 1'b0;
            ST_SHOW: out_valid = 1'b1;
        endcase
        out_fmt     = dec_q.fmt;
        out_op      = dec_q.op;
        out_ra      = dec_q.ra;
        out_rb      = dec_q.rb;
        out_imm8    = dec_q.imm;
        out_disp    = dec_q.disp;
        out_len     = dec_q.len;
        out_illegal = dec_q.bad;
        out_reads_a = dec_q.reads_a;
        out_shift   = dec_q.shift;
        out_trap    = dec_q.trap;
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_op) && $stable(out_ra) && $stable(out_rb)
                       && $stable(out_imm8) && $stable(out_disp) && $stable(out_len)));
    assert_len_values_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_len == LEN_SHORT) || (out_len == LEN_LONG));
    assert_bad_is_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_len == LEN_SHORT && out_op == OPC_BAD
                         && !out_reads_a && !out_shift && out_trap == 2'b00));
    assert_minor_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fmt == 2'd2) |-> !out_illegal);
    assert_trap_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_trap));
    assert_shift_reads_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_shift |-> out_reads_a);
endmodule

// File: tb/opword_decoder_tb_top.sv
`timescale 1ns/1ps
module opword_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0000;
    logic        out_valid;
    logic [1:0]  out_fmt;
    logic [6:0]  out_op;
    logic [3:0]  out_ra, out_rb;
    logic [7:0]  out_imm8;
    logic [9:0]  out_disp;
    logic [2:0]  out_len;
    logic        out_illegal, out_reads_a, out_shift;
    logic [1:0]  out_trap;

    int checks = 0;
    int failures = 0;
    int e_fmt = 0, e_op = 0, e_ra = 0, e_rb = 0, e_imm = 0, e_disp = 0;
    int e_len = 2, e_bad = 0, e_rda = 0, e_sh = 0, e_trap = 0, e_valid = 0;

    always #2 clk = ~clk;

    opword_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_fmt(out_fmt), .out_op(out_op),
        .out_ra(out_ra), .out_rb(out_rb), .out_imm8(out_imm8),
        .out_disp(out_disp), .out_len(out_len), .out_illegal(out_illegal),
        .out_reads_a(out_reads_a), .out_shift(out_shift), .out_trap(out_trap)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [15:0] w);
        int p;
        e_ra = 0; e_rb = 0; e_imm = 0; e_disp = 0; e_len = 2;
        e_bad = 0; e_rda = 0; e_sh = 0; e_trap = 0;
        if (!w[15]) begin
            e_fmt = 1;
            p = int'(w[14:8]);
            e_op = p; e_ra = int'(w[7:4]); e_rb = int'(w[3:0]);
            e_bad = !((p <= 'h0E) || (p >= 'h19 && p <= 'h39));
            if (p inside {'h01, 'h03, 'h08, 'h09, 'h0C, 'h0D, 'h1A, 'h1B, 'h1D,
                          'h1F, 'h20, 'h22, 'h24, 'h30, 'h36, 'h37, 'h38, 'h39})
                e_len = 6;
            if (p inside {'h05, 'h26, 'h27, 'h28, 'h29, 'h2B, 'h2D, 'h2E, 'h2F})
                e_rda = 1;
            if (p inside {'h27, 'h28, 'h2D}) e_sh = 1;
            if (p == 'h30) e_trap = 1;
            if (p == 'h35) e_trap = 2;
        end else if (!w[14]) begin
            e_fmt = 2;
            e_op = 'h40 + int'(w[13:12]);
            e_ra = int'(w[11:8]); e_imm = int'(w[7:0]);
        end else begin
            e_fmt = 3;
            e_disp = int'(w[9:0]);
            if (int'(w[13:10]) >= 10) e_bad = 1;
            else e_op = 'h48 + int'(w[13:10]);
        end
        if (e_bad != 0) begin
            e_op = 'h7F; e_len = 2; e_rda = 0; e_sh = 0; e_trap = 0;
        end
    endfunction

    task automatic compare_all(input string ft, input string lt);
        cmp("R10 out_valid", int'(out_valid), e_valid);
        cmp({"R1 fmt ", ft}, int'(out_fmt), e_fmt);
        cmp({ft, " op"}, int'(out_op), e_op);
        cmp({ft, " ra"}, int'(out_ra), e_ra);
        cmp({ft, " rb"}, int'(out_rb), e_rb);
        cmp({ft, " imm8"}, int'(out_imm8), e_imm);
        cmp({ft, " disp"}, int'(out_disp), e_disp);
        cmp({lt, " len"}, int'(out_len), e_len);
        cmp({ft, " R6 illegal"}, int'(out_illegal), e_bad);
        cmp({ft, " R7 reads_a"}, int'(out_reads_a), e_rda);
        cmp({ft, " R8 shift"}, int'(out_shift), e_sh);
        cmp({ft, " R9 trap"}, int'(out_trap), e_trap);
    endtask

    task automatic step(input logic v, input logic [15:0] w);
        string ft;
        string lt;
        @(negedge clk);
        in_valid = v;
        in_word = w;
        @(posedge clk);
        #1;
        e_valid = int'(v);
        if (v) model(w);
        if (!v)              ft = "R11 hold";
        else if (e_bad != 0) ft = "R6";
        else if (e_fmt == 1) ft = "R2";
        else if (e_fmt == 2) ft = "R3";
        else                 ft = "R4";
        lt = (v && e_bad != 0) ? "R6" : "R5";
        compare_all(ft, lt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R12: reset state before any word
        e_valid = 0; e_fmt = 0; e_op = 0; e_ra = 0; e_rb = 0; e_imm = 0;
        e_disp = 0; e_len = 2; e_bad = 0; e_rda = 0; e_sh = 0; e_trap = 0;
        compare_all("R12 reset", "R12 reset");

        // every primary code of format 1, with bubbles
        for (int p = 0; p < 128; p++) begin
            step(1'b1, {1'b0, 7'(p), 8'((p * 37 + 5) & 255)});
            if (p % 7 == 3) step(1'b0, 16'($urandom));
        end
        // format 2, all sub-operations
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                step(1'b1, {2'b10, 2'(s), 4'(k * 5 + s), 8'(k * 71 + 3)});
        step(1'b0, 16'hFFFF);
        // format 3, all conditions including illegal ones
        for (int c = 0; c < 16; c++)
            step(1'b1, {2'b11, 4'(c), 10'((c * 97 + 1) & 1023)});
        step(1'b0, 16'h0000);
        // mixed random traffic
        for (int i = 0; i < 400; i++)
            step(1'(($urandom % 4) != 0), 16'($urandom));
        step(1'b0, 16'h1234);
        step(1'b0, 16'h8765);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule